// File: doc/BRIEF.md
# Serial Channel Clock Source Selector

This block decides when one serial channel receives and transmits a bit. A programmed clock mode and a source-select bit choose the timing source. The choices are an external clock pin, an external clock gated by per-bit strobes, a baud-rate-generator tick (taken directly or divided by 16), a recovered tick from a DPLL, or an oscillator-rate tick. The block also supplies a 16x reference tick to the DPLL and says when the transmit clock pin should be driven out.

All timing stays in the one system clock domain. The block does not produce derived clocks. It produces single-cycle bit enables. The three external pins (receive clock, transmit clock and the carrier-detect strobe) pass through a two-flop synchronizer. The rising edges of the clock pins become one-cycle pulses. Every output is registered.

Top module: `chan_clk_sel`

## Requirements
- R1: While `rst` is high, the cycle after any clock edge shows all four outputs low, whatever the inputs.
- R2: With mode code 1, both enables are timed by the synchronized rising edge of `rx_clk_in`. `rx_bit_en` pulses only when the synchronized `cd_in` level is high. `tx_bit_en` pulses only when the synchronized `tx_clk_in` level is high. `ref16_tick` stays low.
- R3: With mode code 2, `rx_bit_en` repeats `dpll_tick` and `ref16_tick` repeats `brg_tick`, each one cycle later.
- R4: With mode code 2 and `src_sel` = 0, `tx_bit_en` pulses on each synchronized rising edge of `tx_clk_in`. With `src_sel` = 1, it pulses on the divided-by-16 `brg_tick` stream.
- R5: With mode code 3 and `src_sel` = 0, `ref16_tick` repeats `brg_tick`, and both enables repeat `dpll_tick`.
- R6: With mode code 3 and `src_sel` = 1, both enables repeat `brg_tick` directly and `ref16_tick` stays low.
- R7: With mode code 4, both enables repeat `osc_tick` and `ref16_tick` stays low.
- R8: Mode codes 0, 5, 6 and 7 hold `rx_bit_en`, `tx_bit_en`, `ref16_tick` and `txclk_oe` low.
- R9: The divide-by-16 counter clears in any cycle where `mode` or `src_sel` differs from its value in the previous cycle, and a `brg_tick` in that cycle is not counted. The divided pulse then comes on the 16th counted `brg_tick`, and again on every 16th tick after that.
- R10: `txclk_oe` is high exactly for mode 2 with `src_sel` = 1, mode 3 with `src_sel` = 1, and mode 4.
- R11: A rising edge on an external clock pin that is first sampled at clock edge k shows on the enable outputs right after edge k+2. An internal tick sampled at edge k shows right after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_in | input | 1 | External receive clock pin, asynchronous |
| tx_clk_in | input | 1 | External transmit clock pin, or transmit strobe in mode 1 |
| cd_in | input | 1 | Carrier-detect pin used as the receive strobe in mode 1 |
| osc_tick | input | 1 | Oscillator-rate tick, one cycle wide |
| brg_tick | input | 1 | Baud-rate-generator tick, one cycle wide |
| dpll_tick | input | 1 | Recovered bit tick from the DPLL, one cycle wide |
| mode | input | 3 | Clock mode code (1 to 4 valid) |
| src_sel | input | 1 | Source select: 0 = external/DPLL path, 1 = divided/direct path |
| rx_bit_en | output | 1 | Receive bit enable |
| tx_bit_en | output | 1 | Transmit bit enable |
| txclk_oe | output | 1 | Drive the internal transmit clock out on the transmit clock pin |
| ref16_tick | output | 1 | 16x reference tick to the DPLL |

## Verification
The bench goes after the divider restart. It changes mode or select with and without a coincident `brg_tick`, then counts exactly sixteen ticks. A divider that is not cleared, or that counts the tick in the change cycle, puts its pulse one tick early or on the wrong tick. The bench also checks the strobe gating in mode 1. A design that used the strobe edge instead of its level, or that timed transmit from the transmit pin, shows missing or extra transmit pulses. Random runs through the four unused codes catch leaks onto the enables or the pin-drive output. Directed pin edges check the three-cycle synchronizer latency, which an off-by-one pipeline would miss by a cycle.

// File: rtl/chan_clk_pkg.sv
package chan_clk_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MD_STROBE    = 3'd1;
  localparam logic [MODE_W-1:0] MD_DPLL_RX   = 3'd2;
  localparam logic [MODE_W-1:0] MD_DPLL_BOTH = 3'd3;
  localparam logic [MODE_W-1:0] MD_OSC       = 3'd4;
endpackage

// File: rtl/chan_pin_sync.sv
// Multi-stage synchronizer with rising-edge pulse for an asynchronous pin.
module chan_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], pin};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/chan_div_ref.sv
// Reference divider: pulses on every 2**CNT_W-th tick and restarts on a config change.
module chan_div_ref
  import chan_clk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              src_sel,
  input  logic              tick,
  output logic              div_tick
);
  logic [CNT_W-1:0]  cnt;
  logic [MODE_W-1:0] mode_q;
  logic              sel_q;
  logic              cfg_chg;

  assign cfg_chg  = (mode != mode_q) || (src_sel != sel_q);
  assign div_tick = tick && !cfg_chg && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      sel_q  <= src_sel;
      if (cfg_chg)   cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chan_clk_route.sv
// Combinational routing of timing sources to bit enables per clock mode.
module chan_clk_route
  import chan_clk_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              src_sel,
  input  logic              rx_rise,
  input  logic              tx_rise,
  input  logic              cd_lvl,
  input  logic              tx_lvl,
  input  logic              osc_tick,
  input  logic              brg_tick,
  input  logic              dpll_tick,
  input  logic              div_tick,
  output logic              rx_nxt,
  output logic              tx_nxt,
  output logic              oe_nxt,
  output logic              ref_nxt
);
  always_comb begin
    rx_nxt  = 1'b0;
    tx_nxt  = 1'b0;
    oe_nxt  = 1'b0;
    ref_nxt = 1'b0;
    case (mode)
      MD_STROBE: begin
        rx_nxt = rx_rise & cd_lvl;
        tx_nxt = rx_rise & tx_lvl;
      end
      MD_DPLL_RX: begin
        ref_nxt = brg_tick;
        rx_nxt  = dpll_tick;
        tx_nxt  = src_sel ? div_tick : tx_rise;
        oe_nxt  = src_sel;
      end
      MD_DPLL_BOTH: begin
        if (src_sel) begin
          rx_nxt = brg_tick;
          tx_nxt = brg_tick;
          oe_nxt = 1'b1;
        end else begin
          ref_nxt = brg_tick;
          rx_nxt  = dpll_tick;
          tx_nxt  = dpll_tick;
        end
      end
      MD_OSC: begin
        rx_nxt = osc_tick;
        tx_nxt = osc_tick;
        oe_nxt = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/chan_clk_sel.sv
// Serial channel clock source selector: top level.
module chan_clk_sel
  import chan_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_clk_in,
  input  logic              tx_clk_in,
  input  logic              cd_in,
  input  logic              osc_tick,
  input  logic              brg_tick,
  input  logic              dpll_tick,
  input  logic [MODE_W-1:0] mode,
  input  logic              src_sel,
  output logic              rx_bit_en,
  output logic              tx_bit_en,
  output logic              txclk_oe,
  output logic              ref16_tick
);
  localparam int NPINS = 3;
  logic [NPINS-1:0] pins, lvl, rise;
  logic div_tick;
  logic rx_nxt, tx_nxt, oe_nxt, ref_nxt;

  assign pins = {cd_in, tx_clk_in, rx_clk_in};

  for (genvar i = 0; i < NPINS; i++) begin : g_sync
    chan_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst  (rst),
      .pin  (pins[i]),
      .level(lvl[i]),
      .rise (rise[i])
    );
  end

  chan_div_ref #(.CNT_W(DIV_W)) div_i (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .src_sel (src_sel),
    .tick    (brg_tick),
    .div_tick(div_tick)
  );

  chan_clk_route route_i (
    .mode     (mode),
    .src_sel  (src_sel),
    .rx_rise  (rise[0]),
    .tx_rise  (rise[1]),
    .cd_lvl   (lvl[2]),
    .tx_lvl   (lvl[1]),
    .osc_tick (osc_tick),
    .brg_tick (brg_tick),
    .dpll_tick(dpll_tick),
    .div_tick (div_tick),
    .rx_nxt   (rx_nxt),
    .tx_nxt   (tx_nxt),
    .oe_nxt   (oe_nxt),
    .ref_nxt  (ref_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit_en  <= 1'b0;
      tx_bit_en  <= 1'b0;
      txclk_oe   <= 1'b0;
      ref16_tick <= 1'b0;
    end else begin
      rx_bit_en  <= rx_nxt;
      tx_bit_en  <= tx_nxt;
      txclk_oe   <= oe_nxt;
      ref16_tick <= ref_nxt;
    end
  end
endmodule

// File: rtl/chan_clk_sel_chk.sv
// Property checker attached to the selector top.
module chan_clk_sel_chk
  import chan_clk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              osc_tick,
  input logic              brg_tick,
  input logic              dpll_tick,
  input logic [MODE_W-1:0] mode,
  input logic              src_sel,
  input logic              rx_bit_en,
  input logic              tx_bit_en,
  input logic              txclk_oe,
  input logic              ref16_tick
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rx_bit_en && !tx_bit_en && !txclk_oe && !ref16_tick));

  a_r2_no_ref_strobe: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_STROBE) |=> !ref16_tick);

  a_r3_rx_from_dpll: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DPLL_RX) |=> (rx_bit_en == $past(dpll_tick)));

  a_r6_direct_no_ref: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DPLL_BOTH && src_sel) |=> (!ref16_tick && rx_bit_en == $past(brg_tick)));

  a_r7_osc_both: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_OSC && osc_tick) |=> (rx_bit_en && tx_bit_en));

  a_r8_unsupported_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode > MD_OSC) |=> (!rx_bit_en && !tx_bit_en && !txclk_oe && !ref16_tick));

  a_r9_div_needs_ref: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DPLL_RX && src_sel && !brg_tick) |=> !tx_bit_en);

  a_r10_oe_osc: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_OSC) |=> txclk_oe);
endmodule

bind chan_clk_sel chan_clk_sel_chk chk_i (.*);

// File: tb/chan_clk_sel_tb_top.sv
module chan_clk_sel_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_clk_in = 0, tx_clk_in = 0, cd_in = 0;
  logic osc_tick = 0, brg_tick = 0, dpll_tick = 0;
  logic [2:0] mode = 3'd0;
  logic src_sel = 0;
  logic rx_bit_en, tx_bit_en, txclk_oe, ref16_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string tag_ovr = "";

  // bench model state
  logic hrx[0:3], htx[0:3], hcd[0:3];
  logic [2:0] pm = 3'd0;
  logic ps = 1'b0;
  int cnt = 0;
  logic e_rx = 0, e_tx = 0, e_oe = 0, e_ref = 0;
  logic [2:0] e_mode = 3'd0;
  logic e_sel = 0;

  always #10 clk = ~clk;

  chan_clk_sel dut_i (
    .clk(clk), .rst(rst), .rx_clk_in(rx_clk_in), .tx_clk_in(tx_clk_in),
    .cd_in(cd_in), .osc_tick(osc_tick), .brg_tick(brg_tick), .dpll_tick(dpll_tick),
    .mode(mode), .src_sel(src_sel), .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
    .txclk_oe(txclk_oe), .ref16_tick(ref16_tick)
  );

  function automatic string en_tag(input logic [2:0] m, input logic s);
    case (m)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return s ? "R6" : "R5";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic string tx_tag(input logic [2:0] m, input logic s);
    if (m == 3'd2) return s ? "R9" : "R4";
    return en_tag(m, s);
  endfunction

  task automatic check1(input string req, input logic act, input logic exp, input string what);
    string r;
    r = (tag_ovr != "") ? tag_ovr : req;
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check1(en_tag(e_mode, e_sel), rx_bit_en, e_rx, "rx_bit_en");
    check1(tx_tag(e_mode, e_sel), tx_bit_en, e_tx, "tx_bit_en");
    check1("R10", txclk_oe, e_oe, "txclk_oe");
    check1(en_tag(e_mode, e_sel), ref16_tick, e_ref, "ref16_tick");
  endtask

  // compute expectation for the outputs after the next rising edge
  task automatic predict();
    logic rxr, txr, div, chg;
    for (int i = 3; i > 0; i--) begin
      hrx[i] = hrx[i-1]; htx[i] = htx[i-1]; hcd[i] = hcd[i-1];
    end
    hrx[0] = rx_clk_in; htx[0] = tx_clk_in; hcd[0] = cd_in;
    rxr = hrx[2] & ~hrx[3];
    txr = htx[2] & ~htx[3];
    chg = (mode != pm) || (src_sel != ps);
    div = 1'b0;
    if (chg) cnt = 0;
    else if (brg_tick) begin
      div = (cnt == 15);
      cnt = (cnt + 1) % 16;
    end
    pm = mode; ps = src_sel;
    e_mode = mode; e_sel = src_sel;
    e_rx = 0; e_tx = 0; e_oe = 0; e_ref = 0;
    case (mode)
      3'd1: begin e_rx = rxr & hcd[2]; e_tx = rxr & htx[2]; end
      3'd2: begin
        e_ref = brg_tick; e_rx = dpll_tick;
        e_tx = src_sel ? div : txr; e_oe = src_sel;
      end
      3'd3: begin
        if (src_sel) begin e_rx = brg_tick; e_tx = brg_tick; e_oe = 1; end
        else begin e_ref = brg_tick; e_rx = dpll_tick; e_tx = dpll_tick; end
      end
      3'd4: begin e_rx = osc_tick; e_tx = osc_tick; e_oe = 1; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [2:0] m, input logic s, input logic rc, input logic tc,
                      input logic cd, input logic os, input logic br, input logic dp);
    @(negedge clk);
    compare();
    mode = m; src_sel = s; rx_clk_in = rc; tx_clk_in = tc; cd_in = cd;
    osc_tick = os; brg_tick = br; dpll_tick = dp;
    predict();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin hrx[i] = 0; htx[i] = 0; hcd[i] = 0; end
    // R1: reset dominates busy inputs
    rst = 1; mode = 3'd4; osc_tick = 1; brg_tick = 1; dpll_tick = 1; src_sel = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R1", rx_bit_en, 0, "rx_bit_en in reset");
    check1("R1", tx_bit_en, 0, "tx_bit_en in reset");
    check1("R1", txclk_oe, 0, "txclk_oe in reset");
    check1("R1", ref16_tick, 0, "ref16_tick in reset");
    mode = 0; osc_tick = 0; brg_tick = 0; dpll_tick = 0; src_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    predict();

    // R11: pin edge latency in strobe mode, strobes held high
    tag_ovr = "R11";
    step(3'd1, 0, 0, 1, 1, 0, 0, 0);
    repeat (4) step(3'd1, 0, 0, 1, 1, 0, 0, 0);
    step(3'd1, 0, 1, 1, 1, 0, 0, 0);
    repeat (5) step(3'd1, 0, 1, 1, 1, 0, 0, 0);
    // R2: strobes low gate the edge
    tag_ovr = "R2";
    step(3'd1, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) step(3'd1, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) step(3'd1, 0, 1, 0, 0, 0, 0, 0);
    // R9: divider restart, change cycle carries a tick, then exactly 16
    tag_ovr = "R9";
    step(3'd2, 1, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 20; k++) step(3'd2, 1, 0, 0, 0, 0, 1, 0);
    step(3'd2, 0, 0, 0, 0, 0, 0, 0);
    step(3'd2, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 17; k++) step(3'd2, 1, 0, 0, 0, 0, 1, 0);
    // R11: internal tick latency
    tag_ovr = "R11";
    step(3'd4, 0, 0, 0, 0, 1, 0, 0);
    step(3'd4, 0, 0, 0, 0, 0, 0, 0);
    step(3'd4, 0, 0, 0, 0, 0, 0, 0);
    tag_ovr = "";

    // random blocks across all codes
    for (int b = 0; b < 48; b++) begin
      logic [2:0] m;
      logic s, rc, tc, cd;
      m = 3'($urandom_range(0, 7));
      s = 1'($urandom_range(0, 1));
      rc = rx_clk_in; tc = tx_clk_in; cd = cd_in;
      for (int c = 0; c < 150; c++) begin
        if ($urandom_range(0, 3) == 0) rc = ~rc;
        if ($urandom_range(0, 5) == 0) tc = ~tc;
        if ($urandom_range(0, 6) == 0) cd = ~cd;
        step(m, s, rc, tc, cd, 1'($urandom_range(0, 2) == 0),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      end
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule